// File: doc/BRIEF.md
# Inter-Thread Storage Cell with Bypass Port

This block is one storage cell used by threads to pass words to each other. A mode input selects how the cell behaves. In FIFO mode it is a circular queue whose depth is a power of two. In semaphore mode it holds a single word in storage slot 0. Producers and consumers use a normal push/pop pair. A refused request raises a stall output, and the requester retries later.

A second path, the bypass port, lets a debugger or a runtime look at the cell and patch it without disturbing the queue. A bypass read shows the word that the next pop would return. A bypass write patches the most recently queued word in place. The bypass path never changes the read pointer, the entry count or the flags, and it never stalls.

Occupancy is tracked by a three-state machine: `ST_EMPTY`, `ST_PARTIAL` and `ST_FULL`. The transitions are:
- FIRST_IN: `ST_EMPTY` to `ST_PARTIAL` on an accepted push, or straight to `ST_FULL` when the capacity is one.
- TOP_UP: `ST_PARTIAL` to `ST_FULL` when a lone push fills the last slot.
- LAST_OUT: `ST_PARTIAL` to `ST_EMPTY` when a lone pop takes the only entry.
- RELEASE: `ST_FULL` to `ST_PARTIAL`, or to `ST_EMPTY` when the capacity is one, on an accepted pop.

All other cases hold the state.

Top module: `itc_bypass_cell`

## Requirements
- R1: In FIFO mode (`mode_fifo`=1), `byp_rd_data` is combinational and always equals the storage word at the read pointer, which is the oldest entry. It does not remove that entry.
- R2: In FIFO mode with a nonzero count, a bypass write replaces the word at index (read pointer + count - 1) mod DEPTH, which is the newest entry. This index also applies when the cell is full.
- R3: In FIFO mode with a count of zero, a bypass write changes no storage word.
- R4: In semaphore mode (`mode_fifo`=0), `byp_rd_data` shows storage word 0, and a bypass write changes no storage word.
- R5: A bypass access never stalls and leaves the count, the read pointer, `full` and `empty` unchanged.
- R6: Push and pop follow circular-queue order. `empty` is 1 when the count is 0. In FIFO mode `full` is 1 when the count equals DEPTH.
- R7: A push while `full` is 1 is refused and `push_stall` is 1 in that cycle. A pop while `empty` is 1 is refused and `pop_stall` is 1 in that cycle. Neither refused request changes any state.
- R8: When a push and a bypass write fall in the same cycle, the push is accepted. The bypass write lands on the newest entry as it stood before that push.
- R9: In semaphore mode the capacity is one word at storage index 0. A push writes word 0 and sets `full`. A pop clears the count and does not move the read pointer.
- R10: Reset clears the read pointer and the count, so `empty`=1 and `full`=0. The storage words keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_fifo | input | 1 | 1 = FIFO mode, 0 = semaphore mode |
| push_req | input | 1 | Normal push request |
| push_data | input | DATA_W | Word to push |
| pop_req | input | 1 | Normal pop request |
| pop_data | output | DATA_W | Word that an accepted pop removes |
| full | output | 1 | Cell holds its capacity |
| empty | output | 1 | Cell holds no entry |
| push_stall | output | 1 | Push refused this cycle |
| pop_stall | output | 1 | Pop refused this cycle |
| byp_rd_data | output | DATA_W | Bypass read: oldest entry, or word 0 in semaphore mode |
| byp_wr_en | input | 1 | Bypass write strobe |
| byp_wr_data | input | DATA_W | Bypass write word |

## Verification
A read pointer that goes astray shows up on `byp_rd_data` right away, because that port is combinational from the pointer. A miscounted occupancy shows up in two ways. It bends the bypass write target, which appears once pops bring that slot to the head. It also moves `full` or `empty` one edge after the faulty update. A bypass write that leaks into the count or the pointer changes the flags or the head word on the next cycle. A leak into storage while the cell is empty is exposed by switching to semaphore mode and reading word 0.

// File: rtl/itc_cell_pkg.sv
package itc_cell_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_t;
endpackage

// File: rtl/itc_cell_ctrl.sv
module itc_cell_ctrl
    import itc_cell_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_fifo,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             push_stall,
    output logic             pop_stall
);
    localparam logic [CNT_W-1:0] CAP_FIFO = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_SEM  = CNT_W'(1);

    occ_state_t       state, state_nxt;
    logic [CNT_W-1:0] cap;
    logic [CNT_W-1:0] count_nxt;
    logic [PTR_W-1:0] rd_ptr_nxt;

    assign cap     = mode_fifo ? CAP_FIFO : CAP_SEM;
    assign push_ok = push_req && (state != ST_FULL);
    assign pop_ok  = pop_req  && (state != ST_EMPTY);

    always_comb begin
        count_nxt  = count;
        rd_ptr_nxt = rd_ptr;
        if (push_ok && !pop_ok) count_nxt = count + 1'b1;
        if (pop_ok && !push_ok) count_nxt = count - 1'b1;
        if (pop_ok && mode_fifo) rd_ptr_nxt = rd_ptr + 1'b1;
    end

    // next-state: named transitions FIRST_IN, TOP_UP, LAST_OUT, RELEASE
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: begin
                if (push_ok) state_nxt = (cap == CAP_SEM) ? ST_FULL : ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (push_ok && !pop_ok && (count == cap - 1'b1))
                    state_nxt = ST_FULL;
                else if (pop_ok && !push_ok && (count == CAP_SEM))
                    state_nxt = ST_EMPTY;
            end
            ST_FULL: begin
                if (pop_ok) state_nxt = (cap == CAP_SEM) ? ST_EMPTY : ST_PARTIAL;
            end
            default: state_nxt = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_EMPTY;
            count  <= '0;
            rd_ptr <= '0;
        end else begin
            state  <= state_nxt;
            count  <= count_nxt;
            rd_ptr <= rd_ptr_nxt;
        end
    end

    // outputs
    always_comb begin
        full       = (state == ST_FULL);
        empty      = (state == ST_EMPTY);
        push_stall = push_req && full;
        pop_stall  = pop_req && empty;
    end
endmodule

// File: rtl/itc_cell_store.sv
module itc_cell_store #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              push_we,
    input  logic [PTR_W-1:0]  push_idx,
    input  logic [DATA_W-1:0] push_data,
    input  logic              byp_we,
    input  logic [PTR_W-1:0]  byp_idx,
    input  logic [DATA_W-1:0] byp_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] words [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (push_we && (push_idx == PTR_W'(i)))
                words[i] <= push_data;
            else if (byp_we && (byp_idx == PTR_W'(i)))
                words[i] <= byp_data;
        end
    end

    assign rd_data = words[rd_idx];
endmodule

// File: rtl/itc_cell_bypass.sv
module itc_cell_bypass #(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             mode_fifo,
    input  logic             byp_wr_en,
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [CNT_W-1:0] count,
    output logic [PTR_W-1:0] head_idx,
    output logic [PTR_W-1:0] tail_idx,
    output logic [PTR_W-1:0] newest_idx,
    output logic             byp_we
);
    logic [PTR_W-1:0] cnt_lo;
    assign cnt_lo = count[PTR_W-1:0];

    always_comb begin
        if (mode_fifo) begin
            head_idx   = rd_ptr;
            tail_idx   = rd_ptr + cnt_lo;
            newest_idx = rd_ptr + cnt_lo - 1'b1;
            byp_we     = byp_wr_en && (count != '0);
        end else begin
            head_idx   = '0;
            tail_idx   = '0;
            newest_idx = '0;
            byp_we     = 1'b0;
        end
    end
endmodule

// File: rtl/itc_bypass_cell.sv
module itc_bypass_cell #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_fifo,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    output logic [DATA_W-1:0] pop_data,
    output logic              full,
    output logic              empty,
    output logic              push_stall,
    output logic              pop_stall,
    output logic [DATA_W-1:0] byp_rd_data,
    input  logic              byp_wr_en,
    input  logic [DATA_W-1:0] byp_wr_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic             push_ok, pop_ok, byp_we;
    logic [PTR_W-1:0] rd_ptr, head_idx, tail_idx, newest_idx;
    logic [CNT_W-1:0] count;
    logic [DATA_W-1:0] head_word;

    itc_cell_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_fifo(mode_fifo),
        .push_req(push_req), .pop_req(pop_req),
        .push_ok(push_ok), .pop_ok(pop_ok),
        .rd_ptr(rd_ptr), .count(count),
        .full(full), .empty(empty),
        .push_stall(push_stall), .pop_stall(pop_stall)
    );

    itc_cell_bypass #(.DEPTH(DEPTH)) u_byp (
        .mode_fifo(mode_fifo), .byp_wr_en(byp_wr_en),
        .rd_ptr(rd_ptr), .count(count),
        .head_idx(head_idx), .tail_idx(tail_idx),
        .newest_idx(newest_idx), .byp_we(byp_we)
    );

    itc_cell_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk),
        .push_we(push_ok), .push_idx(tail_idx), .push_data(push_data),
        .byp_we(byp_we), .byp_idx(newest_idx), .byp_data(byp_wr_data),
        .rd_idx(head_idx), .rd_data(head_word)
    );

    assign pop_data    = head_word;
    assign byp_rd_data = head_word;
endmodule

// File: rtl/itc_bypass_cell_props.sv
module itc_bypass_cell_props #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_fifo,
    input logic              push_req,
    input logic              pop_req,
    input logic              byp_wr_en,
    input logic              full,
    input logic              empty,
    input logic              push_stall,
    input logic              pop_stall,
    input logic [DATA_W-1:0] byp_rd_data
);
    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_push_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full) |-> push_stall);

    assert_pop_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty) |-> pop_stall);

    assert_bypass_keeps_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_wr_en && !push_req && !pop_req) |=> ($stable(full) && $stable(empty)));

    assert_empty_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fifo && empty && !push_req && !pop_req) |=> (!mode_fifo || $stable(byp_rd_data)));

    assert_sem_word_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_fifo && !push_req) |=> (mode_fifo || $stable(byp_rd_data)));
endmodule

bind itc_bypass_cell itc_bypass_cell_props #(.DATA_W(DATA_W)) u_props (
    .clk(clk), .rst_n(rst_n), .mode_fifo(mode_fifo),
    .push_req(push_req), .pop_req(pop_req), .byp_wr_en(byp_wr_en),
    .full(full), .empty(empty), .push_stall(push_stall),
    .pop_stall(pop_stall), .byp_rd_data(byp_rd_data)
);

// File: tb/itc_bypass_cell_test.sv
module itc_bypass_cell_test;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_fifo = 1'b1;
    logic          push_req = 1'b0, pop_req = 1'b0, byp_wr_en = 1'b0;
    logic [DW-1:0] push_data = '0, byp_wr_data = '0;
    logic [DW-1:0] pop_data, byp_rd_data;
    logic          full, empty, push_stall, pop_stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    itc_bypass_cell #(.DATA_W(DW), .DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .mode_fifo(mode_fifo),
        .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data),
        .full(full), .empty(empty),
        .push_stall(push_stall), .pop_stall(pop_stall),
        .byp_rd_data(byp_rd_data),
        .byp_wr_en(byp_wr_en), .byp_wr_data(byp_wr_data)
    );

    typedef struct packed {
        logic       m, ps, pp, bw;
        logic [7:0] pd, bd;
        logic       cb, est, eost, eem, efu;
        logic [7:0] eb;
        logic [3:0] rq;
    } vec_t;

    // mode push pop bwr pdata bdata chk_byp exp_pstall exp_ostall exp_empty exp_full exp_byp req
    localparam vec_t VEC [0:24] = '{
        '{1,1,0,0,8'h10,8'h00,1,0,0,0,0,8'h10,4'd6},  // R6 first push
        '{1,0,1,0,8'h00,8'h00,0,0,0,1,0,8'h00,4'd6},  // R6 drain, head now at 1
        '{1,0,0,1,8'h00,8'hAA,0,0,0,1,0,8'h00,4'd3},  // R3 write on empty
        '{0,0,0,0,8'h00,8'h00,1,0,0,1,0,8'h10,4'd3},  // R3 word 0 untouched
        '{0,0,0,1,8'h00,8'hCC,1,0,0,1,0,8'h10,4'd4},  // R4 sem write dropped
        '{0,1,0,0,8'hDD,8'h00,1,0,0,0,1,8'hDD,4'd9},  // R9 sem push
        '{0,0,0,1,8'h00,8'hEE,1,0,0,0,1,8'hDD,4'd4},  // R4 sem write dropped
        '{0,1,0,0,8'h77,8'h00,1,1,0,0,1,8'hDD,4'd7},  // R7 sem push full
        '{0,0,1,0,8'h00,8'h00,1,0,0,1,0,8'hDD,4'd9},  // R9 sem pop
        '{1,1,0,0,8'h11,8'h00,1,0,0,0,0,8'h11,4'd6},  // R6
        '{1,0,0,1,8'h00,8'h22,1,0,0,0,0,8'h22,4'd2},  // R2 newest == oldest
        '{1,1,0,0,8'h33,8'h00,1,0,0,0,0,8'h22,4'd1},  // R1
        '{1,1,0,1,8'h44,8'h45,1,0,0,0,0,8'h22,4'd8},  // R8 push + bypass
        '{1,0,1,0,8'h00,8'h00,1,0,0,0,0,8'h45,4'd8},  // R8 patched pre-push newest
        '{1,0,1,0,8'h00,8'h00,1,0,0,0,0,8'h44,4'd1},  // R1
        '{1,1,0,0,8'h55,8'h00,1,0,0,0,0,8'h44,4'd6},
        '{1,1,0,0,8'h66,8'h00,1,0,0,0,0,8'h44,4'd6},
        '{1,1,0,0,8'h77,8'h00,1,0,0,0,1,8'h44,4'd6},  // R6 full
        '{1,1,0,0,8'h88,8'h00,1,1,0,0,1,8'h44,4'd7},  // R7 push refused
        '{1,0,0,1,8'h00,8'h99,1,0,0,0,1,8'h44,4'd5},  // R5 flags kept
        '{1,0,1,0,8'h00,8'h00,1,0,0,0,0,8'h55,4'd1},
        '{1,0,1,0,8'h00,8'h00,1,0,0,0,0,8'h66,4'd1},
        '{1,0,1,0,8'h00,8'h00,1,0,0,0,0,8'h99,4'd2},  // R2 wrapped newest
        '{1,0,1,0,8'h00,8'h00,1,0,0,1,0,8'h44,4'd6},
        '{1,0,1,0,8'h00,8'h00,1,0,1,1,0,8'h44,4'd7}   // R7 pop refused
    };

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp,
                         input int rq, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic step(input vec_t v);
        @(negedge clk);
        mode_fifo   = v.m;
        push_req    = v.ps;
        pop_req     = v.pp;
        byp_wr_en   = v.bw;
        push_data   = {8{v.pd}};
        byp_wr_data = {8{v.bd}};
        #1;
        check(DW'(push_stall), DW'(v.est), int'(v.rq), "push_stall");
        check(DW'(pop_stall), DW'(v.eost), int'(v.rq), "pop_stall");
        @(posedge clk);
        #1;
        push_req  = 1'b0;
        pop_req   = 1'b0;
        byp_wr_en = 1'b0;
        @(negedge clk);
        check(DW'(empty), DW'(v.eem), int'(v.rq), "empty");
        check(DW'(full), DW'(v.efu), int'(v.rq), "full");
        if (v.cb) check(byp_rd_data, {8{v.eb}}, int'(v.rq), "byp_rd_data");
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(DW'(empty), DW'(1), 10, "empty after reset");
        check(DW'(full), DW'(0), 10, "full after reset");

        for (int i = 0; i < 25; i++) step(VEC[i]);

        // R1: pop_data is the head word, same as the bypass view
        check(pop_data, byp_rd_data, 1, "pop_data vs bypass");

        // R10: push one word (lands at index 3), then reset mid-run
        step('{1,1,0,0,8'h12,8'h00,1,0,0,0,0,8'h12,4'd10});
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(DW'(empty), DW'(1), 10, "empty after mid reset");
        check(DW'(full), DW'(0), 10, "full after mid reset");
        check(byp_rd_data, {8{8'h55}}, 10, "storage kept, head at 0");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule